// File: doc/BRIEF.md
# Multiprocessor-Bit Asynchronous Serial Transmitter

This block sends asynchronous serial frames on one output line. Each frame carries an extra multiprocessor bit, placed between the data bits and the stop bits. The transmitter has two stages of storage: a holding register that the host writes, and a shift register that feeds the line. The host writes the holding register first. It then pulses a clear of the data-empty flag. The transmitter responds by copying the holding register into the shift register and setting the data-empty flag again, which frees the holding register for the next byte.

When the stop bit of a frame begins, the transmitter looks at the data-empty flag:
- If the host has already cleared it again, the next byte is taken at that moment and its start bit follows the last stop bit with no gap.
- Otherwise the transmit-end flag is raised and the line returns to the mark level (1).

Bit timing comes only from a one-cycle baud tick input. Every bit lasts 16 ticks.

The frame settings are sampled when a byte is loaded into the shift register:
- data length (7 or 8 bits),
- stop-bit count (1 or 2),
- multiprocessor bit value.

Each flag has an interrupt request output. The request is the flag gated by its enable.

The controller has five states, named `ST_IDLE`, `ST_START`, `ST_DATA`, `ST_MPB` and `ST_STOP`, with these transitions:
- **idle-load:** `ST_IDLE` goes to `ST_START` when the data-empty flag is 0.
- **start-done:** `ST_START` goes to `ST_DATA` at the end of the start bit.
- **data-done:** `ST_DATA` goes to `ST_MPB` after the last data bit.
- **mpb-done:** `ST_MPB` goes to `ST_STOP`. This is where the data-empty flag is sampled.
- **stop-chain:** `ST_STOP` goes to `ST_START` after the last stop bit when a next byte was taken.
- **stop-end:** `ST_STOP` goes to `ST_IDLE` after the last stop bit when no next byte was taken.

Top module: `mpx_serial_tx`

## Requirements
- R1: After reset, the line `txd` is 1, `empty_flag` is 1 and `end_flag` is 1.
- R2: A frame on `txd` is, in order:
  - one start bit of 0,
  - the data bits, least significant bit first,
  - one multiprocessor bit,
  - the stop bits of 1.

  Every bit lasts 16 baud ticks.
- R3: When `len_short` is 1 at load, 7 data bits are sent (bits 6..0). When it is 0, 8 data bits are sent.
- R4: When `two_stop` is 1 at load, the frame has 2 stop bits. When it is 0, it has 1 stop bit.
- R5: The multiprocessor bit sent equals `mpb_sel` at the time the byte is loaded.
- R6: In idle, a one-cycle `empty_clr` pulse clears `empty_flag` and `end_flag` on the next edge. The byte is loaded on the edge after that, which sets `empty_flag` to 1 and starts the start bit. Writing the holding register without `empty_clr` leaves `txd` at 1.
- R7: If `empty_flag` is 0 when the stop bit of a frame begins, the next frame's start bit follows that frame's last stop bit directly, and `end_flag` stays 0.
- R8: If `empty_flag` is 1 when the stop bit begins, `end_flag` is set at that point. After the stop bits, `txd` stays at 1.
- R9: `empty_irq` equals `empty_flag` AND `empty_ie`. `end_irq` equals `end_flag` AND `end_ie`.
- R10: Changing `len_short`, `two_stop` or `mpb_sel` while a frame is in progress does not alter that frame. The changed values take effect with the next load.
- R11: Bit timing advances only on cycles with `baud_tick` at 1. With one tick every three cycles, a bit lasts 48 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle baud enable (16 per bit) |
| hold_we | input | 1 | Write strobe for the holding register |
| hold_din | input | DW | Holding register write data |
| empty_clr | input | 1 | Pulse that clears the data-empty flag |
| mpb_sel | input | 1 | Multiprocessor bit value for the next frame |
| len_short | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| two_stop | input | 1 | 1 = two stop bits, 0 = one |
| empty_ie | input | 1 | Data-empty interrupt enable |
| end_ie | input | 1 | Transmit-end interrupt enable |
| txd | output | 1 | Serial output line |
| empty_flag | output | 1 | Data-empty flag |
| end_flag | output | 1 | Transmit-end flag |
| empty_irq | output | 1 | Data-empty interrupt request (level) |
| end_irq | output | 1 | Transmit-end interrupt request (level) |

## Verification
After an `empty_clr` pulse:
- the flags change on the first clock edge,
- the load and the start bit follow on the second edge,
- each later bit boundary comes 16 ticks after the previous one.

The bench therefore checks the flags one cycle after the pulse and the load one cycle after that. To read a frame, it finds the falling edge of the start bit and then samples at the middle of each bit: 8 tick periods after the edge, then every 16 tick periods. This leaves margin for the phase of the tick. The transmit-end flag is read in the middle of the last stop bit, after it has been set or left clear at the start of the first stop bit. A chained frame is proven by finding a 0 exactly one bit period after the middle of the last stop bit.

// File: rtl/mpx_tx_pkg.sv
package mpx_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_MPB,
        ST_STOP
    } tx_state_e;
endpackage

// File: rtl/mpx_tx_bitclk.sv
module mpx_tx_bitclk #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic restart,
    output logic bit_done
);
    localparam int CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (run && tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign bit_done = run && tick && !restart && (cnt == LAST);
endmodule

// File: rtl/mpx_tx_flags.sv
module mpx_tx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic host_clr,
    input  logic load_set,
    input  logic end_set,
    input  logic empty_ie,
    input  logic end_ie,
    output logic empty_flag,
    output logic end_flag,
    output logic empty_irq,
    output logic end_irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_flag <= 1'b1;
            end_flag   <= 1'b1;
        end else begin
            if (load_set)      empty_flag <= 1'b1;
            else if (host_clr) empty_flag <= 1'b0;
            if (end_set)       end_flag   <= 1'b1;
            else if (host_clr) end_flag   <= 1'b0;
        end
    end

    assign empty_irq = empty_flag & empty_ie;
    assign end_irq   = end_flag & end_ie;
endmodule

// File: rtl/mpx_tx_fsm.sv
module mpx_tx_fsm
    import mpx_tx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_done,
    input  logic          empty_flag,
    input  logic [DW-1:0] hold_q,
    input  logic          len_short,
    input  logic          two_stop,
    input  logic          mpb_in,
    output logic          load_pulse,
    output logic          end_set,
    output logic          run,
    output logic          restart,
    output logic          txd
);
    localparam int IW = $clog2(DW + 1);
    localparam logic [IW-1:0] LAST_LONG  = IW'(DW - 1);
    localparam logic [IW-1:0] LAST_SHORT = IW'(DW - 2);

    tx_state_e     state, state_nx;
    logic [DW-1:0] shreg;
    logic [IW-1:0] idx;
    logic          cur_short, cur_two, cur_mpb, nxt_two;
    logic          chain, stop_idx;
    logic          data_last, stop_last;

    assign data_last = (idx == (cur_short ? LAST_SHORT : LAST_LONG));
    assign stop_last = (stop_idx == cur_two);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (!empty_flag) state_nx = ST_START;
            ST_START: if (bit_done) state_nx = ST_DATA;
            ST_DATA:  if (bit_done && data_last) state_nx = ST_MPB;
            ST_MPB:   if (bit_done) state_nx = ST_STOP;
            ST_STOP:  if (bit_done && stop_last) state_nx = chain ? ST_START : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // frame datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            idx       <= '0;
            cur_short <= 1'b0;
            cur_two   <= 1'b0;
            cur_mpb   <= 1'b0;
            nxt_two   <= 1'b0;
            chain     <= 1'b0;
            stop_idx  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (!empty_flag) begin
                        shreg     <= hold_q;
                        cur_short <= len_short;
                        cur_two   <= two_stop;
                        cur_mpb   <= mpb_in;
                        idx       <= '0;
                    end
                end
                ST_START: begin
                    idx <= '0;
                end
                ST_DATA: begin
                    if (bit_done) begin
                        shreg <= shreg >> 1;
                        idx   <= idx + 1'b1;
                    end
                end
                ST_MPB: begin
                    if (bit_done) begin
                        stop_idx <= 1'b0;
                        chain    <= !empty_flag;
                        if (!empty_flag) begin
                            shreg     <= hold_q;
                            cur_short <= len_short;
                            cur_mpb   <= mpb_in;
                            nxt_two   <= two_stop;
                        end
                    end
                end
                ST_STOP: begin
                    if (bit_done) begin
                        stop_idx <= 1'b1;
                        if (stop_last && chain) cur_two <= nxt_two;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        txd        = 1'b1;
        load_pulse = 1'b0;
        end_set    = 1'b0;
        restart    = 1'b0;
        run        = (state != ST_IDLE);
        unique case (state)
            ST_IDLE: begin
                load_pulse = !empty_flag;
                restart    = !empty_flag;
            end
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg[0];
            ST_MPB: begin
                txd        = cur_mpb;
                load_pulse = bit_done && !empty_flag;
                end_set    = bit_done && empty_flag;
            end
            ST_STOP:  txd = 1'b1;
            default:  txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/mpx_serial_tx.sv
module mpx_serial_tx #(
    parameter int DW            = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          hold_we,
    input  logic [DW-1:0] hold_din,
    input  logic          empty_clr,
    input  logic          mpb_sel,
    input  logic          len_short,
    input  logic          two_stop,
    input  logic          empty_ie,
    input  logic          end_ie,
    output logic          txd,
    output logic          empty_flag,
    output logic          end_flag,
    output logic          empty_irq,
    output logic          end_irq
);
    logic [DW-1:0] hold_q;
    logic          bit_done, load_pulse, end_set, run, restart;

    always_ff @(posedge clk) begin
        if (!rst_n)       hold_q <= '0;
        else if (hold_we) hold_q <= hold_din;
    end

    mpx_tx_bitclk #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_bitclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .run      (run),
        .restart  (restart),
        .bit_done (bit_done)
    );

    mpx_tx_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_clr   (empty_clr),
        .load_set   (load_pulse),
        .end_set    (end_set),
        .empty_ie   (empty_ie),
        .end_ie     (end_ie),
        .empty_flag (empty_flag),
        .end_flag   (end_flag),
        .empty_irq  (empty_irq),
        .end_irq    (end_irq)
    );

    mpx_tx_fsm #(.DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_done   (bit_done),
        .empty_flag (empty_flag),
        .hold_q     (hold_q),
        .len_short  (len_short),
        .two_stop   (two_stop),
        .mpb_in     (mpb_sel),
        .load_pulse (load_pulse),
        .end_set    (end_set),
        .run        (run),
        .restart    (restart),
        .txd        (txd)
    );
endmodule

// File: rtl/mpx_tx_checker.sv
module mpx_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic empty_clr,
    input logic empty_flag,
    input logic end_flag,
    input logic txd,
    input logic bit_done
);
    // R8: transmit-end is only ever raised with nothing pending
    assert_end_implies_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        end_flag |-> empty_flag);

    // R6: only a host clear can drop the data-empty flag
    assert_empty_fall_by_host_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(empty_flag) |-> $past(empty_clr));

    // R8: transmit-end rises as the stop bit starts, line high
    assert_end_rise_line_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_flag) |-> txd);

    // R11: a bit boundary needs a baud tick
    assert_bit_needs_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bit_done |-> baud_tick);
endmodule

bind mpx_serial_tx mpx_tx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .empty_clr  (empty_clr),
    .empty_flag (empty_flag),
    .end_flag   (end_flag),
    .txd        (txd),
    .bit_done   (bit_done)
);

// File: tb/tb_mpx_serial_tx.sv
`timescale 1ns/1ps
module tb_mpx_serial_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b1;
    logic       hold_we = 1'b0;
    logic [7:0] hold_din = 8'h00;
    logic       empty_clr = 1'b0;
    logic       mpb_sel = 1'b0;
    logic       len_short = 1'b0;
    logic       two_stop = 1'b0;
    logic       empty_ie = 1'b0;
    logic       end_ie = 1'b0;
    logic       txd, empty_flag, end_flag, empty_irq, end_irq;

    int checks = 0;
    int failures = 0;
    int tick_p = 1;
    int tcnt = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mpx_serial_tx dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .hold_we(hold_we), .hold_din(hold_din), .empty_clr(empty_clr),
        .mpb_sel(mpb_sel), .len_short(len_short), .two_stop(two_stop),
        .empty_ie(empty_ie), .end_ie(end_ie), .txd(txd),
        .empty_flag(empty_flag), .end_flag(end_flag),
        .empty_irq(empty_irq), .end_irq(end_irq)
    );

    always @(negedge clk) begin
        if (tcnt >= tick_p - 1) begin
            tcnt <= 0;
            baud_tick <= 1'b1;
        end else begin
            tcnt <= tcnt + 1;
            baud_tick <= 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired act=%0d exp=0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic write_hold(input logic [7:0] d);
        @(negedge clk);
        hold_we = 1'b1;
        hold_din = d;
        @(negedge clk);
        hold_we = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        empty_clr = 1'b1;
        @(negedge clk);
        empty_clr = 1'b0;
    endtask

    task automatic wait_bit();
        repeat (16 * tick_p) @(negedge clk);
    endtask

    // leaves the caller at the middle of the start bit
    task automatic find_start(input string tag);
        int n = 0;
        while (txd !== 1'b0 && n < 4000) begin
            @(negedge clk);
            n++;
        end
        repeat (8 * tick_p) @(negedge clk);
        chk({tag, " start bit"}, {31'd0, txd}, 32'd0);
    endtask

    // starts at the middle of the start bit, ends at the middle of the last stop bit
    task automatic rx_body(input int nbits, input int nstop,
                           output logic [7:0] data, output logic mpb, output logic stops_ok);
        data = 8'h00;
        stops_ok = 1'b1;
        for (int i = 0; i < nbits; i++) begin
            wait_bit();
            data[i] = txd;
        end
        wait_bit();
        mpb = txd;
        for (int s = 0; s < nstop; s++) begin
            wait_bit();
            if (txd !== 1'b1) stops_ok = 1'b0;
        end
    endtask

    // data[10:3], len_short[2], mpb_sel[1], two_stop[0]
    localparam logic [10:0] VEC [6] = '{
        {8'hA5, 1'b0, 1'b1, 1'b0},
        {8'h3C, 1'b0, 1'b0, 1'b1},
        {8'hFF, 1'b1, 1'b0, 1'b0},
        {8'h81, 1'b1, 1'b1, 1'b1},
        {8'h00, 1'b0, 1'b1, 1'b0},
        {8'h5A, 1'b0, 1'b0, 1'b0}
    };

    initial begin
        logic [7:0] got;
        logic       gmpb, gstop;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 txd", {31'd0, txd}, 32'd1);
        chk("R1 empty_flag", {31'd0, empty_flag}, 32'd1);
        chk("R1 end_flag", {31'd0, end_flag}, 32'd1);

        // R9: requests follow flag AND enable
        chk("R9 empty_irq disabled", {31'd0, empty_irq}, 32'd0);
        chk("R9 end_irq disabled", {31'd0, end_irq}, 32'd0);
        empty_ie = 1'b1;
        end_ie = 1'b1;
        @(negedge clk);
        chk("R9 empty_irq enabled", {31'd0, empty_irq}, 32'd1);
        chk("R9 end_irq enabled", {31'd0, end_irq}, 32'd1);

        // R6: a holding write alone does not start a frame
        write_hold(8'h96);
        begin
            int lows = 0;
            for (int k = 0; k < 100; k++) begin
                @(negedge clk);
                if (txd !== 1'b1) lows++;
            end
            chk("R6 no start without clear", lows, 0);
        end

        // R6: clear, then load one cycle later
        pulse_clr();
        chk("R6 empty cleared", {31'd0, empty_flag}, 32'd0);
        chk("R6 end cleared", {31'd0, end_flag}, 32'd0);
        chk("R9 empty_irq follows flag", {31'd0, empty_irq}, 32'd0);
        @(negedge clk);
        chk("R6 empty set at load", {31'd0, empty_flag}, 32'd1);
        chk("R6 start bit at load", {31'd0, txd}, 32'd0);
        find_start("R6");
        rx_body(8, 1, got, gmpb, gstop);
        chk("R6 data", {24'd0, got}, 32'h96);
        chk("R8 end set after lone frame", {31'd0, end_flag}, 32'd1);
        wait_bit();
        chk("R8 mark after stop", {31'd0, txd}, 32'd1);
        wait_bit();
        chk("R8 mark held", {31'd0, txd}, 32'd1);

        // R2 R3 R4 R5: vector table
        for (int v = 0; v < 6; v++) begin
            logic [7:0] d;
            logic [7:0] exp_d;
            d = VEC[v][10:3];
            len_short = VEC[v][2];
            mpb_sel = VEC[v][1];
            two_stop = VEC[v][0];
            exp_d = VEC[v][2] ? {1'b0, d[6:0]} : d;
            write_hold(d);
            pulse_clr();
            find_start("R2");
            rx_body(VEC[v][2] ? 7 : 8, VEC[v][0] ? 2 : 1, got, gmpb, gstop);
            chk("R2 R3 data LSB first", {24'd0, got}, {24'd0, exp_d});
            chk("R5 mpb bit", {31'd0, gmpb}, {31'd0, VEC[v][1]});
            chk("R4 stop bits high", {31'd0, gstop}, 32'd1);
            chk("R8 end flag", {31'd0, end_flag}, 32'd1);
            repeat (40) @(negedge clk);
        end

        // R7 R10 R4: chained frames, settings changed mid-frame
        len_short = 1'b0;
        two_stop = 1'b0;
        mpb_sel = 1'b1;
        write_hold(8'hC3);
        pulse_clr();
        while (txd !== 1'b0) @(negedge clk);
        len_short = 1'b1;
        two_stop = 1'b1;
        mpb_sel = 1'b0;
        write_hold(8'hB7);
        pulse_clr();
        find_start("R7");
        rx_body(8, 1, got, gmpb, gstop);
        chk("R10 first frame 8 bits", {24'd0, got}, 32'hC3);
        chk("R10 first frame mpb", {31'd0, gmpb}, 32'd1);
        chk("R7 end flag stays clear", {31'd0, end_flag}, 32'd0);
        wait_bit();
        chk("R7 R10 next start after one stop", {31'd0, txd}, 32'd0);
        rx_body(7, 2, got, gmpb, gstop);
        chk("R7 R3 second frame data", {24'd0, got}, 32'h37);
        chk("R7 R5 second frame mpb", {31'd0, gmpb}, 32'd0);
        chk("R4 second frame two stops", {31'd0, gstop}, 32'd1);
        chk("R8 end after chain", {31'd0, end_flag}, 32'd1);
        chk("R9 end_irq after chain", {31'd0, end_irq}, 32'd1);
        repeat (40) @(negedge clk);

        // R11: one tick every three cycles
        tick_p = 3;
        len_short = 1'b0;
        two_stop = 1'b0;
        mpb_sel = 1'b1;
        repeat (4) @(negedge clk);
        write_hold(8'h6D);
        pulse_clr();
        find_start("R11");
        rx_body(8, 1, got, gmpb, gstop);
        chk("R11 data at slow tick", {24'd0, got}, 32'h6D);
        chk("R11 mpb at slow tick", {31'd0, gmpb}, 32'd1);
        chk("R11 stop at slow tick", {31'd0, gstop}, 32'd1);
        wait_bit();
        chk("R11 mark after slow frame", {31'd0, txd}, 32'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule